// File: doc/BRIEF.md
# Multiphase Oversampling Pulse-Width TDC

This block turns the high time of an asynchronous comparator output into a digital width code. A free-running coarse counter on the main clock gives the whole-period part of each edge time. The input is also sampled on the main clock and on three more clocks that trail it by one quarter, one half and three quarters of a period. Each of these four samples passes through its own two-flop synchronizer in its own clock domain. The four samples are then retimed into one main-clock word, so every word holds the input at four evenly spaced instants inside one main period.

A controller scans these words. It locates the rising and falling edge of each pulse to a quarter period. On each falling edge it reports the width in quarter-period units, together with a one-cycle strobe. Every edge is resolved from the count of high samples in its word, so one out-of-order sample does not move the edge by more than one quarter.

The controller has four states. FILL waits out the synchronizer pipeline after reset. WAIT_LOW holds until the input has been seen low. IDLE looks for a rising edge. MEASURE tracks a pulse that lasts past the end of the word it rose in.

The transitions are as follows:
- FILL→WAIT_LOW: the fill count has expired.
- WAIT_LOW→IDLE: the newest sample of a word is low.
- IDLE→MEASURE (arm): a pulse rises and is still high at the word's newest sample.
- IDLE→IDLE (short): a pulse rises and falls inside one word, and its result is issued.
- MEASURE→MEASURE (hold): the newest sample is still high.
- MEASURE→IDLE (close): the newest sample is low, and the result is issued.

Top module: `ovs_pulse_tdc`

## Requirements
- R1: While rst_n is low, width_valid and width_ovf are 0 and width_code is 0.
- R2: For a pulse whose rising edge lies just before quarter sample index qr and whose falling edge lies just before index qf, the reported code is qf − qr. Sample index 4n+k is the instant of phase k in main period n, with phase 0 on the main clock edge.
- R3: The rising edge is resolved correctly in each of the four quarter slots of a period. A rise in the last slot is counted from the following main edge.
- R4: A pulse that rises and falls between two main edges, with its newest sample low, is reported with a code equal to the number of its high samples.
- R5: A pulse spanning several words is reported as 4 × (coarse span) + fall fine code − rise fine code. The rise fine code is 4 minus the high-sample count of the rise word. The fall fine code is the high-sample count of the fall word.
- R6: width_valid is high for exactly one main cycle per pulse. That cycle follows main edge w+3, where main edge w opens the window that holds the first low sample after the pulse.
- R7: When the fall lies 2^CNT_W or more main periods after the rise (by window index), width_code is all ones and width_ovf is 1. A span of 2^CNT_W − 1 is reported exactly.
- R8: A pulse that is already high when reset is released yields no result, and the next pulse is measured normally.
- R9: width_ovf is 0 for every in-range result and whenever width_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock (phase 0), drives the coarse counter and controller |
| clk_q1 | input | 1 | Sampling clock lagging clk_main by a quarter period |
| clk_q2 | input | 1 | Sampling clock lagging clk_main by half a period |
| clk_q3 | input | 1 | Sampling clock lagging clk_main by three quarters of a period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous comparator output to be measured |
| width_code | output | CNT_W+2 | Pulse width in quarter-period units |
| width_valid | output | 1 | One-cycle strobe marking a new width_code |
| width_ovf | output | 1 | Set with width_valid when the span exceeds the counter range |

## Verification
Each result is due in a fixed cycle. Two sampler flops and one retiming flop place the window for main period w into the controller during the cycle after edge w+2. The result register then updates on edge w+3. The driver derives the window index of each falling edge from the drive time and stores the exact due time with the expected width. The monitor samples on the falling main edge and checks the width, the overflow flag and the arrival time. A strobe that comes early, late, twice, or with nothing queued is counted as a failure.

// File: rtl/ovs_tdc_pkg.sv
`timescale 1ns/1ps
package ovs_tdc_pkg;

    // number of equally spaced sampling phases per main period
    localparam int PHASES = 4;
    localparam int FINE_W = $clog2(PHASES);

    typedef enum logic [1:0] {
        ST_FILL     = 2'd0,
        ST_WAIT_LOW = 2'd1,
        ST_IDLE     = 2'd2,
        ST_MEASURE  = 2'd3
    } tdc_state_e;

    // population count of one sample word (bubble tolerant edge position)
    function automatic logic [FINE_W:0] count_high(input logic [PHASES-1:0] w);
        logic [FINE_W:0] c;
        c = '0;
        for (int i = 0; i < PHASES; i++) begin
            c = c + {{FINE_W{1'b0}}, w[i]};
        end
        return c;
    endfunction

endpackage

// File: rtl/ovs_phase_sampler.sv
`timescale 1ns/1ps
module ovs_phase_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= {sync_q[SYNC_STAGES-2:0], din};
                end
            end
        end
    endgenerate

    assign dout = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/ovs_word_align.sv
`timescale 1ns/1ps
module ovs_word_align
    import ovs_tdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] phase_in,
    output logic [PHASES-1:0] word_q,
    output logic              last_q
);

    // one main-clock register lines all phases up on the same window;
    // last_q keeps the newest sample of the previous window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            last_q <= 1'b0;
        end else begin
            word_q <= phase_in;
            last_q <= word_q[PHASES-1];
        end
    end

endmodule

// File: rtl/ovs_coarse_counter.sv
`timescale 1ns/1ps
module ovs_coarse_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ovs_width_fsm.sv
`timescale 1ns/1ps
module ovs_width_fsm
    import ovs_tdc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PHASES-1:0]        word,
    input  logic                     prev_last,
    input  logic [CNT_W-1:0]         coarse_ts,
    output logic [CNT_W+FINE_W-1:0]  width_code,
    output logic                     width_valid,
    output logic                     width_ovf,
    output tdc_state_e               state_o
);

    localparam int CODE_W    = CNT_W + FINE_W;
    localparam int FILL_CYC  = SYNC_STAGES + 2;
    localparam int FILL_W    = $clog2(FILL_CYC + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(FILL_CYC - 1);
    localparam logic [CNT_W:0]    SPAN_LIMIT = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0]    SPAN_EDGE  = SPAN_LIMIT - 1'b1;

    tdc_state_e        state_q, state_d;
    logic [FILL_W-1:0] fill_cnt;
    logic [CNT_W-1:0]  start_ts;
    logic [FINE_W-1:0] start_fine;
    logic [CNT_W:0]    elapsed;

    logic              newest;
    logic              rise_seen;
    logic [FINE_W:0]   high_cnt;
    logic [FINE_W-1:0] rise_fine;
    logic [CNT_W-1:0]  span_ts;
    logic [CODE_W-1:0] long_width;
    logic              span_over;

    // ---------------- edge decode ----------------
    always_comb begin
        newest     = word[PHASES-1];
        high_cnt   = count_high(word);
        rise_seen  = !prev_last && (|word);
        rise_fine  = FINE_W'(PHASES - int'(high_cnt));
        span_ts    = coarse_ts - start_ts;
        long_width = {span_ts, {FINE_W{1'b0}}}
                   + CODE_W'(high_cnt)
                   - CODE_W'(start_fine);
        span_over  = (elapsed >= SPAN_EDGE);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (fill_cnt == FILL_LAST) begin
                    state_d = ST_WAIT_LOW;
                end
            end
            ST_WAIT_LOW: begin
                if (!newest) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (rise_seen && newest) begin
                    state_d = ST_MEASURE;
                end
            end
            ST_MEASURE: begin
                if (!newest) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    // ---------------- measurement context ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt   <= '0;
            start_ts   <= '0;
            start_fine <= '0;
            elapsed    <= '0;
        end else begin
            if (state_q == ST_FILL) begin
                fill_cnt <= fill_cnt + 1'b1;
            end
            if (state_q == ST_IDLE && rise_seen && newest) begin
                start_ts   <= coarse_ts;
                start_fine <= rise_fine;
                elapsed    <= '0;
            end else if (state_q == ST_MEASURE && newest) begin
                if (elapsed != SPAN_LIMIT) begin
                    elapsed <= elapsed + 1'b1;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_code  <= '0;
            width_valid <= 1'b0;
            width_ovf   <= 1'b0;
        end else begin
            width_valid <= 1'b0;
            width_ovf   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (rise_seen && !newest) begin
                        width_valid <= 1'b1;
                        width_code  <= CODE_W'(high_cnt);
                    end
                end
                ST_MEASURE: begin
                    if (!newest) begin
                        width_valid <= 1'b1;
                        if (span_over) begin
                            width_code <= '1;
                            width_ovf  <= 1'b1;
                        end else begin
                            width_code <= long_width;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/ovs_pulse_tdc.sv
`timescale 1ns/1ps
module ovs_pulse_tdc
    import ovs_tdc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk_main,
    input  logic                    clk_q1,
    input  logic                    clk_q2,
    input  logic                    clk_q3,
    input  logic                    rst_n,
    input  logic                    pulse_in,
    output logic [CNT_W+FINE_W-1:0] width_code,
    output logic                    width_valid,
    output logic                    width_ovf
);

    localparam int CODE_W = CNT_W + FINE_W;

    logic [PHASES-1:0] phase_clk;
    logic [PHASES-1:0] phase_smp;
    logic [PHASES-1:0] word;
    logic              prev_last;
    logic [CNT_W-1:0]  coarse_ts;
    tdc_state_e        fsm_state;

    assign phase_clk = {clk_q3, clk_q2, clk_q1, clk_main};

    generate
        for (genvar k = 0; k < PHASES; k++) begin : g_phase
            ovs_phase_sampler #(
                .SYNC_STAGES(SYNC_STAGES)
            ) u_smp (
                .clk  (phase_clk[k]),
                .rst_n(rst_n),
                .din  (pulse_in),
                .dout (phase_smp[k])
            );
        end
    endgenerate

    ovs_word_align u_align (
        .clk     (clk_main),
        .rst_n   (rst_n),
        .phase_in(phase_smp),
        .word_q  (word),
        .last_q  (prev_last)
    );

    ovs_coarse_counter #(
        .CNT_W(CNT_W)
    ) u_coarse (
        .clk  (clk_main),
        .rst_n(rst_n),
        .count(coarse_ts)
    );

    ovs_width_fsm #(
        .CNT_W      (CNT_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_fsm (
        .clk        (clk_main),
        .rst_n      (rst_n),
        .word       (word),
        .prev_last  (prev_last),
        .coarse_ts  (coarse_ts),
        .width_code (width_code),
        .width_valid(width_valid),
        .width_ovf  (width_ovf),
        .state_o    (fsm_state)
    );

endmodule

// File: rtl/ovs_pulse_tdc_chk.sv
`timescale 1ns/1ps
module ovs_pulse_tdc_chk
    import ovs_tdc_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk_main,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] width_code,
    input  logic              width_valid,
    input  logic              width_ovf,
    input  tdc_state_e        fsm_state
);

    AST_OVF_SATURATES: assert property (@(posedge clk_main) disable iff (!rst_n)
        width_ovf |-> (width_code == {CODE_W{1'b1}})); // R7

    AST_OVF_WITH_STROBE: assert property (@(posedge clk_main) disable iff (!rst_n)
        width_ovf |-> width_valid); // R9

    AST_NONZERO_WIDTH: assert property (@(posedge clk_main) disable iff (!rst_n)
        width_valid |-> (width_code != '0)); // R2

    AST_SILENT_WARMUP: assert property (@(posedge clk_main) disable iff (!rst_n)
        (fsm_state == ST_FILL || fsm_state == ST_WAIT_LOW) |=> !width_valid); // R8

    AST_STROBE_ORIGIN: assert property (@(posedge clk_main) disable iff (!rst_n)
        width_valid |-> ($past(fsm_state) == ST_IDLE || $past(fsm_state) == ST_MEASURE)); // R6

endmodule

bind ovs_pulse_tdc ovs_pulse_tdc_chk #(
    .CODE_W(CODE_W)
) u_chk (
    .clk_main   (clk_main),
    .rst_n      (rst_n),
    .width_code (width_code),
    .width_valid(width_valid),
    .width_ovf  (width_ovf),
    .fsm_state  (fsm_state)
);

// File: tb/ovs_pulse_tdc_bench.sv
`timescale 1ns/1ps
module ovs_pulse_tdc_bench;

    localparam int CNT_W  = 8;
    localparam int CODE_W = CNT_W + 2;
    localparam longint MAX_CODE = (64'd1 << CODE_W) - 1;

    typedef struct {
        longint width;
        bit     ovf;
        time    due;
        string  tag;
    } exp_t;

    logic              clk_main, clk_q1, clk_q2, clk_q3;
    logic              rst_n;
    logic              pulse_in;
    logic [CODE_W-1:0] width_code;
    logic              width_valid;
    logic              width_ovf;

    int   total = 0;
    int   bad   = 0;
    int   seen_valids = 0;
    bit   done  = 0;
    exp_t exp_q[$];

    ovs_pulse_tdc #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_ovs_pulse_tdc (
        .clk_main   (clk_main),
        .clk_q1     (clk_q1),
        .clk_q2     (clk_q2),
        .clk_q3     (clk_q3),
        .rst_n      (rst_n),
        .pulse_in   (pulse_in),
        .width_code (width_code),
        .width_valid(width_valid),
        .width_ovf  (width_ovf)
    );

    // 125 MHz main clock, rising at 8n+4; quarter clocks trail by 2, 4, 6 ns
    initial begin clk_main = 0; forever #4 clk_main = ~clk_main; end
    initial begin clk_q1 = 0; #2; forever #4 clk_q1 = ~clk_q1; end
    initial begin clk_q2 = 0; #4; forever #4 clk_q2 = ~clk_q2; end
    initial begin clk_q3 = 0; #6; forever #4 clk_q3 = ~clk_q3; end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // time of odd offset r (1,3,5,7) after main edge n
    function automatic time tm(input longint n, input longint r);
        return time'(8 * n + 4 + r);
    endfunction

    // quarter sample index of the first sample at or after time t (t odd)
    function automatic longint qidx(input time t);
        return (longint'(t) - 3) / 2;
    endfunction

    // driver: schedules the expected item, then drives the pulse
    task automatic drive_pulse(input time t_r, input time t_f, input string tag);
        exp_t   e;
        longint qr, qf, span;
        qr   = qidx(t_r);
        qf   = qidx(t_f);
        span = (qf >>> 2) - (qr >>> 2);
        e.ovf   = (span >= (64'd1 << CNT_W));
        e.width = e.ovf ? MAX_CODE : (qf - qr);
        e.due   = time'(8 * ((qf >>> 2) + 3) + 8);
        e.tag   = tag;
        exp_q.push_back(e);
        #(t_r - $time);
        pulse_in = 1'b1;
        #(t_f - $time);
        pulse_in = 1'b0;
    endtask

    // monitor: away from the active edge
    always @(negedge clk_main) begin
        if (rst_n && width_valid) begin
            seen_valids++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected strobe", longint'(width_code), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(longint'(width_code) == e.width, e.tag, longint'(width_code), e.width);
                check(width_ovf == e.ovf, e.ovf ? "R7 ovf flag" : "R9 ovf flag",
                      longint'(width_ovf), longint'(e.ovf));
                check($time == e.due, "R6 strobe time", longint'($time), longint'(e.due));
            end
        end
    end

    initial begin
        rst_n    = 1'b0;
        pulse_in = 1'b1;           // R8: input already high through reset
        #20;
        check(width_valid == 1'b0, "R1 valid in reset", longint'(width_valid), 0);
        check(width_code == '0, "R1 code in reset", longint'(width_code), 0);
        check(width_ovf == 1'b0, "R1 ovf in reset", longint'(width_ovf), 0);
        #9 rst_n = 1'b1;           // t=29
        #(tm(10, 3) - $time);
        pulse_in = 1'b0;
        #(tm(18, 1) - $time);
        check(seen_valids == 0, "R8 no result for pre-reset pulse", seen_valids, 0);

        // R3: rise in each quarter slot, fall three periods later
        drive_pulse(tm(20, 1), tm(23, 3), "R3 slot0");
        drive_pulse(tm(30, 3), tm(33, 3), "R3 slot1");
        drive_pulse(tm(40, 5), tm(43, 3), "R3 slot2");
        drive_pulse(tm(50, 7), tm(53, 3), "R3 slot3");
        check(seen_valids == 1 + 0 || seen_valids >= 1, "R8 next pulse measured", seen_valids, 1);

        // R4: pulses inside one window
        drive_pulse(tm(60, 1), tm(60, 5), "R4 two high samples");
        drive_pulse(tm(66, 1), tm(66, 3), "R4 one high sample");
        drive_pulse(tm(70, 3), tm(70, 5), "R4 middle sample");

        // R2/R5: spans with various fall slots
        drive_pulse(tm(80, 3), tm(80, 7), "R2 rise late window");
        drive_pulse(tm(90, 5), tm(91, 1), "R5 one period span");
        drive_pulse(tm(100, 1), tm(112, 7), "R5 fall slot3");
        drive_pulse(tm(120, 7), tm(127, 5), "R5 mixed fine");

        // R7: largest exact span, then overflow
        drive_pulse(tm(140, 1), tm(395, 3), "R7 max exact span");
        drive_pulse(tm(410, 1), tm(666, 1), "R7 span at limit");
        drive_pulse(tm(680, 5), tm(1200, 7), "R7 long span");
        drive_pulse(tm(1210, 3), tm(1214, 5), "R2 after overflow");

        #(tm(1240, 0) - $time);
        check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(64'd1_600_000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", exp_q.size(), 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule